// File: doc/BRIEF.md
# Byte-Masked Forwarding Store Buffer

This block sits between a core's store port and a data cache. Stores enter a small in-order queue as an 8-byte word address, 64 bits of data and an 8-bit byte enable, and leave the queue in program order through the cache write port. Loads do not wait for the queue to empty. A load looks up every buffered entry in the same cycle that the cache read for it starts. The lookup yields a forwarded data word and a per-byte mask of the bytes the buffer supplies. One cycle later, when the cache data arrives, the result is built lane by lane: buffer byte where the mask is set, cache byte otherwise.

A load that overlaps only part of the buffered data therefore finishes through this merge, with no stall cycle. Loads can complete while older stores are still queued, so other agents may see a store and a later load in the opposite order.

Both store interfaces use valid/ready. On the store side, a store is taken on a rising clock edge where `st_valid` and `st_ready` are both high. `st_ready` is low only when the queue is full. A store offered while `st_ready` is low is dropped, and the producer keeps it until `st_ready` returns. On the drain side, `dr_valid` stays high while any entry is queued, and the head fields stay fixed until an edge where `dr_ready` is high. That edge removes the entry. The load probe has no back-pressure: every `ld_req` returns a result.

Top module: `sbuf_fwd_top`

## Requirements
- R1: The queue holds at most 8 entries. `st_ready` is 0 exactly when 8 entries are held. A store offered while `st_ready` is 0 is not stored, and a later load to its word gets a mask of 0.
- R2: `dr_valid` is 1 exactly when at least one entry is queued. Entries leave through `dr_waddr`/`dr_data`/`dr_be` in the order they were accepted, one per edge where `dr_ready` is 1. While `dr_ready` is 0, the head fields hold steady.
- R3: A load whose word matches no queued entry gets `ld_fwd_mask` = 0, and `ld_data` equals `cache_rdata`.
- R4: For each byte lane b (lane b is bits 8b+7:8b), `ld_data` takes the forwarded byte when `ld_fwd_mask[b]` is 1 and the `cache_rdata` byte otherwise. A partly overlapping load completes in the same fixed time.
- R5: A mask bit b is set when some queued entry with the load's word address has `be[b]` = 1. If several entries write the same byte, the youngest one supplies it.
- R6: `ld_valid` is 1 in the cycle right after each cycle in which `ld_req` is 1, and 0 otherwise. `ld_data` in that cycle is merged with the `cache_rdata` present in that same cycle.
- R7: A store accepted on the same edge as a load probe is not visible to that load. It is visible to loads probed in later cycles.
- R8: An entry being drained is still visible to a load probed in the cycle it is accepted by the cache. It is not visible to loads probed afterwards.
- R9: After reset, the queue is empty: `sb_empty` = 1, `st_ready` = 1, `dr_valid` = 0, `ld_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can take a store (not full) |
| st_waddr | input | WAW (13) | Store 8-byte word address |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables, bit b = lane b |
| dr_valid | output | 1 | Head entry offered to cache |
| dr_ready | input | 1 | Cache takes the head entry |
| dr_waddr | output | WAW (13) | Head entry word address |
| dr_data | output | 64 | Head entry data |
| dr_be | output | 8 | Head entry byte enables |
| ld_req | input | 1 | Load probe this cycle (cache read starts) |
| ld_waddr | input | WAW (13) | Load word address |
| cache_rdata | input | 64 | Cache read data, one cycle after `ld_req` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Merged load value |
| ld_fwd_mask | output | 8 | Lanes supplied by the buffer |
| sb_empty | output | 1 | No entries queued |

## Verification
A wrong occupancy count shows up at once: `st_ready` or `dr_valid` is wrong in the next cycle, or the drain port emits a stale or repeated entry at the next accepted drain. A wrong age order or a stale valid window in the lookup surfaces as a wrong `ld_fwd_mask` bit or byte exactly one cycle after the probe. The bench therefore probes words that several entries write, probes on the very edges where entries arrive and leave, and compares each drained entry against its own record of program order.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int LANES = 8;
  localparam int DW    = LANES * 8;

  typedef logic [DW-1:0]    word_t;
  typedef logic [LANES-1:0] lanes_t;

  function automatic word_t merge_lanes(input word_t fwd, input lanes_t sel, input word_t cache);
    word_t r;
    for (int b = 0; b < LANES; b++) begin
      r[b*8 +: 8] = sel[b] ? fwd[b*8 +: 8] : cache[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WAW   = 13,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [WAW-1:0] push_waddr,
  input  word_t          push_data,
  input  lanes_t         push_be,
  input  logic           pop,
  output logic [WAW-1:0] ent_waddr [DEPTH],
  output word_t          ent_data  [DEPTH],
  output lanes_t         ent_be    [DEPTH],
  output logic [PW-1:0]  rd_ptr,
  output logic [CW-1:0]  count,
  output logic           full,
  output logic           empty
);
  logic [PW-1:0] wr_ptr;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(i)) begin
        ent_waddr[i] <= push_waddr;
        ent_data[i]  <= push_data;
        ent_be[i]    <= push_be;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never passes the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2: nothing is removed from an empty queue
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push) |=> (count == '0));
endmodule

// File: rtl/sbuf_probe.sv
module sbuf_probe
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WAW   = 13,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic [WAW-1:0] ent_waddr [DEPTH],
  input  word_t          ent_data  [DEPTH],
  input  lanes_t         ent_be    [DEPTH],
  input  logic [PW-1:0]  rd_ptr,
  input  logic [CW-1:0]  count,
  input  logic [WAW-1:0] ld_waddr,
  output word_t          fwd_data,
  output lanes_t         fwd_mask
);
  logic [DEPTH-1:0] age_live;
  logic [DEPTH-1:0] age_hit;
  logic [PW-1:0]    age_idx [DEPTH];

  // Age slot k names the k-th oldest queued entry
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age_idx[k]  = rd_ptr + PW'(k);
    assign age_live[k] = (CW'(k) < count);
    assign age_hit[k]  = age_live[k] && (ent_waddr[age_idx[k]] == ld_waddr);
  end

  // Per lane, walk from oldest to youngest so the youngest writer wins
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_comb begin
      fwd_mask[b]       = 1'b0;
      fwd_data[b*8 +: 8] = 8'h00;
      for (int k = 0; k < DEPTH; k++) begin
        if (age_hit[k] && ent_be[age_idx[k]][b]) begin
          fwd_mask[b]        = 1'b1;
          fwd_data[b*8 +: 8] = ent_data[age_idx[k]][b*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/sbuf_merge.sv
module sbuf_merge
  import sbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_req,
  input  word_t  fwd_data,
  input  lanes_t fwd_mask,
  input  word_t  cache_rdata,
  output logic   ld_valid,
  output word_t  ld_data,
  output lanes_t ld_fwd_mask
);
  word_t fwd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid    <= 1'b0;
      ld_fwd_mask <= '0;
      fwd_q       <= '0;
    end else begin
      ld_valid <= ld_req;
      if (ld_req) begin
        ld_fwd_mask <= fwd_mask;
        fwd_q       <= fwd_data;
      end
    end
  end

  assign ld_data = merge_lanes(fwd_q, ld_fwd_mask, cache_rdata);

  // R4: lanes without a mask bit pass cache data unchanged
  a_r4_cache_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ((ld_data & ~{{8{ld_fwd_mask[7]}}, {8{ld_fwd_mask[6]}}, {8{ld_fwd_mask[5]}},
                                 {8{ld_fwd_mask[4]}}, {8{ld_fwd_mask[3]}}, {8{ld_fwd_mask[2]}},
                                 {8{ld_fwd_mask[1]}}, {8{ld_fwd_mask[0]}}})
                  == (cache_rdata & ~{{8{ld_fwd_mask[7]}}, {8{ld_fwd_mask[6]}}, {8{ld_fwd_mask[5]}},
                                 {8{ld_fwd_mask[4]}}, {8{ld_fwd_mask[3]}}, {8{ld_fwd_mask[2]}},
                                 {8{ld_fwd_mask[1]}}, {8{ld_fwd_mask[0]}}})));
endmodule

// File: rtl/sbuf_fwd_top.sv
module sbuf_fwd_top
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WAW   = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_valid,
  output logic           st_ready,
  input  logic [WAW-1:0] st_waddr,
  input  logic [63:0]    st_data,
  input  logic [7:0]     st_be,
  output logic           dr_valid,
  input  logic           dr_ready,
  output logic [WAW-1:0] dr_waddr,
  output logic [63:0]    dr_data,
  output logic [7:0]     dr_be,
  input  logic           ld_req,
  input  logic [WAW-1:0] ld_waddr,
  input  logic [63:0]    cache_rdata,
  output logic           ld_valid,
  output logic [63:0]    ld_data,
  output logic [7:0]     ld_fwd_mask,
  output logic           sb_empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WAW-1:0] ent_waddr [DEPTH];
  word_t          ent_data  [DEPTH];
  lanes_t         ent_be    [DEPTH];
  logic [PW-1:0]  rd_ptr;
  logic [CW-1:0]  count;
  logic           full;
  logic           empty;
  logic           push;
  logic           pop;
  word_t          fwd_data;
  lanes_t         fwd_mask;

  assign st_ready = !full;
  assign dr_valid = !empty;
  assign sb_empty = empty;
  assign push     = st_valid && !full;
  assign pop      = dr_ready && !empty;
  assign dr_waddr = ent_waddr[rd_ptr];
  assign dr_data  = ent_data[rd_ptr];
  assign dr_be    = ent_be[rd_ptr];

  sbuf_queue #(.DEPTH(DEPTH), .WAW(WAW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_waddr(st_waddr), .push_data(st_data), .push_be(st_be),
    .pop(pop),
    .ent_waddr(ent_waddr), .ent_data(ent_data), .ent_be(ent_be),
    .rd_ptr(rd_ptr), .count(count), .full(full), .empty(empty)
  );

  sbuf_probe #(.DEPTH(DEPTH), .WAW(WAW)) u_probe (
    .ent_waddr(ent_waddr), .ent_data(ent_data), .ent_be(ent_be),
    .rd_ptr(rd_ptr), .count(count), .ld_waddr(ld_waddr),
    .fwd_data(fwd_data), .fwd_mask(fwd_mask)
  );

  sbuf_merge u_merge (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req),
    .fwd_data(fwd_data), .fwd_mask(fwd_mask), .cache_rdata(cache_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_fwd_mask(ld_fwd_mask)
  );

  // R6: one result per probe, exactly one cycle later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> ld_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |=> !ld_valid);

  // R3: an empty queue forwards nothing
  a_r3_empty_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_empty && ld_req) |=> (ld_fwd_mask == '0));

  // R2: head held while the cache stalls; no offer when empty
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_waddr) && $stable(dr_data) && $stable(dr_be)));
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sb_empty |-> !dr_valid);

  // R1: a refused store leaves the queue full
  a_r1_refused_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready && !(dr_valid && dr_ready)) |=> !st_ready);
endmodule

// File: tb/sbuf_fwd_top_test.sv
module sbuf_fwd_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAW = 13;
  localparam int NV  = 11;

  // Vector table: kind (0 store, 1 load), word address, store data or cache data, byte enables
  localparam logic        V_KIND [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 1};
  localparam logic [12:0] V_ADDR [NV] = '{13'h020, 13'h020, 13'h041, 13'h021, 13'h020,
                                          13'h020, 13'h041, 13'h021, 13'h060, 13'h021, 13'h021};
  localparam logic [63:0] V_DATA [NV] = '{64'h1111111111111111, 64'h2222222222222222,
                                          64'h3333333333333333, 64'h5555555555555555,
                                          64'h4444444444444444, 64'hAAAAAAAAAAAAAAAA,
                                          64'h0123456789ABCDEF, 64'hFFEEDDCCBBAA9988,
                                          64'h7766554433221100, 64'h6666666666666666,
                                          64'hC3C3C3C3C3C3C3C3};
  localparam logic [7:0]  V_BE   [NV] = '{8'hFF, 8'h0F, 8'hF0, 8'h03, 8'h30,
                                          8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00};

  logic           clk = 0;
  logic           rst_n;
  logic           st_valid, st_ready;
  logic [WAW-1:0] st_waddr;
  logic [63:0]    st_data;
  logic [7:0]     st_be;
  logic           dr_valid, dr_ready;
  logic [WAW-1:0] dr_waddr;
  logic [63:0]    dr_data;
  logic [7:0]     dr_be;
  logic           ld_req;
  logic [WAW-1:0] ld_waddr;
  logic [63:0]    cache_rdata;
  logic           ld_valid;
  logic [63:0]    ld_data;
  logic [7:0]     ld_fwd_mask;
  logic           sb_empty;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench record of queued stores in program order
  logic [WAW-1:0] m_waddr [16];
  logic [63:0]    m_data  [16];
  logic [7:0]     m_be    [16];
  int m_head = 0;
  int m_cnt  = 0;

  // Pending load expectation
  bit          pend = 0;
  logic [63:0] pend_fd;
  logic [7:0]  pend_fm;
  string       pend_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbuf_fwd_top #(.DEPTH(8), .WAW(WAW)) uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_waddr(dr_waddr), .dr_data(dr_data), .dr_be(dr_be),
    .ld_req(ld_req), .ld_waddr(ld_waddr), .cache_rdata(cache_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_fwd_mask(ld_fwd_mask), .sb_empty(sb_empty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Oldest to youngest, so younger writers overwrite lanes (R5)
  task automatic model_fwd(input logic [WAW-1:0] a, output logic [63:0] fd, output logic [7:0] fm);
    fd = '0;
    fm = '0;
    for (int k = 0; k < m_cnt; k++) begin
      int i = (m_head + k) % 16;
      if (m_waddr[i] == a) begin
        for (int b = 0; b < 8; b++) begin
          if (m_be[i][b]) begin
            fm[b] = 1'b1;
            fd[b*8 +: 8] = m_data[i][b*8 +: 8];
          end
        end
      end
    end
  endtask

  function automatic logic [63:0] exp_merge(input logic [63:0] fd, input logic [7:0] fm, input logic [63:0] cd);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = fm[b] ? fd[b*8 +: 8] : cd[b*8 +: 8];
    return r;
  endfunction

  // One clock cycle; cd is the cache data for the load probed in the previous step
  task automatic step(input logic sv, input logic [WAW-1:0] sa, input logic [63:0] sd, input logic [7:0] sb,
                      input logic lv, input logic [WAW-1:0] la, input logic drr,
                      input logic [63:0] cd, input string tag);
    bit acc_st, acc_dr;
    logic [63:0] fd;
    logic [7:0]  fm;
    @(negedge clk);
    st_valid = sv; st_waddr = sa; st_data = sd; st_be = sb;
    ld_req = lv; ld_waddr = la; dr_ready = drr; cache_rdata = cd;
    #1;
    chk({"R6 ld_valid ", pend_tag}, 64'(ld_valid), 64'(pend));
    if (pend) begin
      chk({"R5 mask ", pend_tag}, 64'(ld_fwd_mask), 64'(pend_fm));
      chk({"R4 data ", pend_tag}, ld_data, exp_merge(pend_fd, pend_fm, cd));
    end
    pend = lv;
    pend_tag = tag;
    if (lv) begin
      model_fwd(la, fd, fm);
      pend_fd = fd;
      pend_fm = fm;
    end
    acc_st = sv && st_ready;
    acc_dr = drr && dr_valid;
    if (acc_dr) begin
      chk({"R2 drain addr ", tag}, 64'(dr_waddr), 64'(m_waddr[m_head]));
      chk({"R2 drain data ", tag}, dr_data, m_data[m_head]);
      chk({"R2 drain be ", tag}, 64'(dr_be), 64'(m_be[m_head]));
    end
    @(posedge clk);
    if (acc_dr) begin
      m_head = (m_head + 1) % 16;
      m_cnt--;
    end
    if (acc_st) begin
      int t = (m_head + m_cnt) % 16;
      m_waddr[t] = sa; m_data[t] = sd; m_be[t] = sb;
      m_cnt++;
    end
    #1;
    st_valid = 0; ld_req = 0; dr_ready = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] prev_cd;
    rst_n = 0; st_valid = 0; st_waddr = '0; st_data = '0; st_be = '0;
    dr_ready = 0; ld_req = 0; ld_waddr = '0; cache_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk("R9 sb_empty", 64'(sb_empty), 64'd1);
    chk("R9 st_ready", 64'(st_ready), 64'd1);
    chk("R9 dr_valid", 64'(dr_valid), 64'd0);
    chk("R9 ld_valid", 64'(ld_valid), 64'd0);

    // R3: load to an empty queue
    step(0, '0, '0, '0, 1, 13'h020, 0, '0, "R3 empty");
    prev_cd = 64'h9876543210FEDCBA;

    // Table walk: stores, youngest-wins loads (R5), partial merges (R4), miss (R3)
    for (int v = 0; v < NV; v++) begin
      if (V_KIND[v] == 1'b0)
        step(1, V_ADDR[v], V_DATA[v], V_BE[v], 0, '0, 0, prev_cd, "R5 table store");
      else
        step(0, '0, '0, '0, 1, V_ADDR[v], 0, prev_cd, "R4 table load");
      prev_cd = V_DATA[v] ^ 64'h5A5A5A5A5A5A5A5A;
    end
    step(0, '0, '0, '0, 0, '0, 0, prev_cd, "flush");
    @(negedge clk); #1;
    chk("R2 head held while stalled", 64'(dr_waddr), 64'h020);
    chk("R2 dr_valid with entries", 64'(dr_valid), 64'd1);

    // R7: store and load to the same new word on the same edge
    step(1, 13'h070, 64'hDEADBEEFCAFEF00D, 8'hFF, 1, 13'h070, 0, '0, "R7 same-edge");
    step(0, '0, '0, '0, 1, 13'h070, 0, 64'h0F0F0F0F0F0F0F0F, "R7 later");
    step(1, 13'h071, 64'h1234123412341234, 8'h81, 0, '0, 0, 64'h1111000011110000, "fill");
    @(negedge clk); #1;
    chk("R1 st_ready low when full", 64'(st_ready), 64'd0);

    // R1: store offered while full is dropped
    step(1, 13'h072, 64'hFFFFFFFFFFFFFFFF, 8'hFF, 0, '0, 0, '0, "R1 refused");
    step(0, '0, '0, '0, 1, 13'h072, 0, '0, "R1 refused not visible");

    // R8: head drains on the same edge as a load to its word
    step(0, '0, '0, '0, 1, 13'h020, 1, 64'hABCDABCDABCDABCD, "R8 drain edge");
    step(0, '0, '0, '0, 1, 13'h020, 0, 64'h3C3C3C3C3C3C3C3C, "R8 after drain");
    step(0, '0, '0, '0, 0, '0, 0, 64'h9999888877776666, "flush");
    @(negedge clk); #1;
    chk("R1 st_ready after drain", 64'(st_ready), 64'd1);

    // R2: drain the rest in order
    while (m_cnt > 0) step(0, '0, '0, '0, 0, '0, 1, '0, "R2 drain");
    @(negedge clk); #1;
    chk("R2 dr_valid when empty", 64'(dr_valid), 64'd0);
    chk("R2 sb_empty when empty", 64'(sb_empty), 64'd1);
    step(0, '0, '0, '0, 1, 13'h070, 0, '0, "R3 after drain");
    step(0, '0, '0, '0, 0, '0, 0, 64'h0000FFFF0000FFFF, "R3 after drain result");
    finish_run();
  end
endmodule